// File: doc/BRIEF.md
# SPI Register Transaction Engine with Target Wait-States

This block is a SPI master that performs a single register access, either a read or a write of 1 to 64 bytes, against a target that exposes its registers through a FIFO-style transaction format. A host raises `start_i` for one cycle with the direction, a 16-bit register address, the byte count and, for a write, the payload. The engine pulls chip-select low and shifts out a four-byte command header. It then clocks single filler bytes until the target signals readiness, moves the payload, and finally releases chip-select.

The target may stall after the header for as long as it needs. The engine samples bit 0 of every byte received after the header, and the first byte with that bit set ends the stall. If no ready byte arrives within a programmable number of polled bytes, the engine abandons the access, releases the bus and reports a timeout. A byte count outside 1..64 is refused at once and the bus is not touched. The command inputs and the write payload must stay stable while `busy_o` is high.

Top module: `tpm_spi_xact`

## Requirements
- R1: Command header byte 0 has bit 7 set to 1 for a read and 0 for a write, bit 6 at 0, and bits 5:0 equal to the byte count minus one.
- R2: Header byte 1 is the constant 0xD4. Header byte 2 is address bits 15:8 and header byte 3 is address bits 7:0.
- R3: A start with a byte count of 0 or above 64 produces `done_o` on the next cycle with `err_o` = 2'b01, and chip-select never goes low.
- R4: After the header, the engine clocks single 0x00 bytes while chip-select stays low, until it receives a byte with bit 0 set. The data phase starts with the byte that follows.
- R5: Bit 0 of the bytes received during the four header bytes has no effect. Polling always follows the header.
- R6: If `poll_lim_i` consecutive polled bytes (a limit of 0 counts as 1) all have bit 0 clear, the access ends after the last of them with `done_o`, `err_o` = 2'b10 and chip-select released. No data byte is moved.
- R7: On a write, payload byte k is `wdata_i[8k+7:8k]` and is the k-th data byte on MOSI. Received bytes are ignored.
- R8: On a read, MOSI carries 0x00 and the k-th received data byte lands in `rdata_o[8k+7:8k]`. Multi-byte values are therefore least significant byte first. A successful access reports `err_o` = 2'b00.
- R9: SPI mode 0, most significant bit first. SCLK idles low, and MOSI changes only while SCLK is low. MISO is sampled at the rising SCLK edge, and SCLK stays low while chip-select is high.
- R10: Each accepted access has exactly one chip-select low period, which covers all header, poll and data bytes. Chip-select rises in the same cycle as the one-cycle `done_o` pulse, and `busy_o` is low from that cycle on.
- R11: After reset, chip-select is high, SCLK and MOSI are low, and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request, accepted while idle |
| rd_i | input | 1 | 1 = register read, 0 = register write |
| addr_i | input | 16 | Register address |
| len_i | input | 7 | Byte count, valid range 1..64 |
| poll_lim_i | input | 16 | Maximum number of polled bytes before timeout |
| wdata_i | input | 512 | Write payload, byte k in bits 8k+7:8k |
| rdata_o | output | 512 | Read payload, byte k in bits 8k+7:8k |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | 00 ok, 01 bad length, 10 wait-state timeout; valid from done |
| spi_cs_n_o | output | 1 | Chip-select, active low |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Master data out |
| spi_miso_i | input | 1 | Target data in |

## Verification
The assertions check the bus discipline on every cycle. SCLK stays low while chip-select is high, MOSI holds while SCLK is high, chip-select is high whenever the engine is idle, and `done_o` lasts a single cycle. They also check the one-cycle refusal of an illegal byte count. Only the bench scenarios can show byte-level content: the header encoding, the filler bytes, the payload ordering, how many wait-states are tolerated before timeout, and the fact that ready bits seen during the header are ignored. For this the bench uses a target model that stalls for a chosen number of bytes.

// File: rtl/tpmx_pkg.sv
package tpmx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_POLL = 2'd2,
    PH_DATA = 2'd3
  } tpmx_phase_e;

  typedef enum logic [1:0] {
    XERR_NONE    = 2'b00,
    XERR_LEN     = 2'b01,
    XERR_TIMEOUT = 2'b10
  } tpmx_err_e;

  localparam int unsigned HDR_BYTES = 4;
  localparam logic [7:0]  HDR_TAG   = 8'hD4;
  localparam logic [7:0]  FILL_BYTE = 8'h00;
endpackage

// File: rtl/tpmx_byte_shifter.sv
// One SPI mode-0 byte per kick: MSB first, MISO captured as SCLK rises,
// MOSI advanced as SCLK falls. Each SCLK half lasts SCK_HALF clocks.
module tpmx_byte_shifter #(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int unsigned CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SCK_HALF - 1);

  logic          act_q, act_n;
  logic          sclk_q, sclk_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [2:0]    bit_q, bit_n;
  logic [7:0]    tx_q, tx_n;
  logic [7:0]    rx_q, rx_n;
  logic          done_q, done_n;

  always_comb begin
    act_n  = act_q;
    sclk_n = sclk_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    done_n = 1'b0;
    if (!act_q) begin
      if (kick_i) begin
        act_n  = 1'b1;
        tx_n   = tx_i;
        cnt_n  = '0;
        bit_n  = '0;
        sclk_n = 1'b0;
      end
    end else if (cnt_q == CNT_LAST) begin
      cnt_n  = '0;
      sclk_n = ~sclk_q;
      if (!sclk_q) begin
        rx_n = {rx_q[6:0], miso_i};
      end else begin
        tx_n  = {tx_q[6:0], 1'b0};
        bit_n = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          act_n  = 1'b0;
          done_n = 1'b1;
        end
      end
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      sclk_q <= sclk_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      done_q <= done_n;
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = act_q & tx_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/tpmx_xact_fsm.sv
// Sequences header, wait-state polling and data phases; owns chip-select.
module tpmx_xact_fsm
  import tpmx_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 64,
  parameter int unsigned POLL_W    = 16,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int unsigned IDX_W    = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [POLL_W-1:0] poll_lim_i,
  input  logic              byte_done_i,
  input  logic              rx_ready_i,
  output tpmx_phase_e       phase_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              kick_o,
  output logic              cs_n_o,
  output logic              done_o,
  output tpmx_err_e         err_o
);
  tpmx_phase_e       phase_q, phase_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [POLL_W-1:0] polls_q, polls_n;
  logic              kick_q, kick_n;
  logic              cs_n_q, cs_n_nx;
  logic              done_q, done_n;
  tpmx_err_e         err_q, err_n;

  logic              len_bad;
  logic [IDX_W-1:0]  last_idx;
  logic [POLL_W:0]   lim_eff;
  logic              poll_expired;

  assign len_bad  = (len_i == '0) || (len_i > LEN_W'(MAX_BYTES));
  assign last_idx = IDX_W'(len_i - LEN_W'(1));
  assign lim_eff  = (poll_lim_i == '0) ? (POLL_W+1)'(1) : {1'b0, poll_lim_i};
  assign poll_expired = ({1'b0, polls_q} + (POLL_W+1)'(1)) >= lim_eff;

  always_comb begin
    phase_n = phase_q;
    idx_n   = idx_q;
    polls_n = polls_q;
    kick_n  = 1'b0;
    cs_n_nx = cs_n_q;
    done_n  = 1'b0;
    err_n   = err_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          if (len_bad) begin
            done_n = 1'b1;
            err_n  = XERR_LEN;
          end else begin
            phase_n = PH_HDR;
            idx_n   = '0;
            cs_n_nx = 1'b0;
            kick_n  = 1'b1;
            err_n   = XERR_NONE;
          end
        end
      end
      PH_HDR: begin
        if (byte_done_i) begin
          kick_n = 1'b1;
          if (idx_q == IDX_W'(HDR_BYTES - 1)) begin
            phase_n = PH_POLL;
            polls_n = '0;
          end else begin
            idx_n = idx_q + IDX_W'(1);
          end
        end
      end
      PH_POLL: begin
        if (byte_done_i) begin
          if (rx_ready_i) begin
            phase_n = PH_DATA;
            idx_n   = '0;
            kick_n  = 1'b1;
          end else if (poll_expired) begin
            phase_n = PH_IDLE;
            cs_n_nx = 1'b1;
            done_n  = 1'b1;
            err_n   = XERR_TIMEOUT;
          end else begin
            polls_n = polls_q + POLL_W'(1);
            kick_n  = 1'b1;
          end
        end
      end
      PH_DATA: begin
        if (byte_done_i) begin
          if (idx_q == last_idx) begin
            phase_n = PH_IDLE;
            cs_n_nx = 1'b1;
            done_n  = 1'b1;
          end else begin
            idx_n  = idx_q + IDX_W'(1);
            kick_n = 1'b1;
          end
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      polls_q <= '0;
      kick_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= XERR_NONE;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
      polls_q <= polls_n;
      kick_q  <= kick_n;
      cs_n_q  <= cs_n_nx;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign kick_o  = kick_q;
  assign cs_n_o  = cs_n_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/tpmx_rx_store.sv
// Byte-addressed capture register for read payload.
module tpmx_rx_store #(
  parameter int unsigned MAX_BYTES = 64,
  localparam int unsigned IDX_W    = $clog2(MAX_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [7:0]             byte_i,
  output logic [MAX_BYTES*8-1:0] data_o
);
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    logic       en;
    logic [7:0] q;
    assign en = we_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= byte_i;
      end
    end
    assign data_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/tpm_spi_xact.sv
module tpm_spi_xact
  import tpmx_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 64,
  parameter int unsigned SCK_HALF  = 2,
  parameter int unsigned POLL_W    = 16,
  parameter int unsigned ADDR_W    = 16,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int unsigned IDX_W    = $clog2(MAX_BYTES),
  localparam int unsigned DATA_W   = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [POLL_W-1:0] poll_lim_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic              spi_cs_n_o,
  output logic              spi_sclk_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  tpmx_phase_e      phase;
  tpmx_err_e        err;
  logic [IDX_W-1:0] idx;
  logic             kick;
  logic             byte_done;
  logic [7:0]       rx_byte;
  logic [7:0]       tx_byte;
  logic [LEN_W-1:0] len_m1;
  logic [15:0]      addr16;
  logic             store_en;

  assign len_m1 = len_i - LEN_W'(1);
  assign addr16 = 16'(addr_i);

  tpmx_xact_fsm #(
    .MAX_BYTES (MAX_BYTES),
    .POLL_W    (POLL_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .poll_lim_i  (poll_lim_i),
    .byte_done_i (byte_done),
    .rx_ready_i  (rx_byte[0]),
    .phase_o     (phase),
    .idx_o       (idx),
    .kick_o      (kick),
    .cs_n_o      (spi_cs_n_o),
    .done_o      (done_o),
    .err_o       (err)
  );

  // Byte presented to the shifter at each kick.
  always_comb begin
    tx_byte = FILL_BYTE;
    unique case (phase)
      PH_HDR: begin
        unique case (idx[1:0])
          2'd0:    tx_byte = {rd_i, 7'(len_m1)};
          2'd1:    tx_byte = HDR_TAG;
          2'd2:    tx_byte = addr16[15:8];
          default: tx_byte = addr16[7:0];
        endcase
      end
      PH_DATA: tx_byte = rd_i ? FILL_BYTE : wdata_i[idx*8 +: 8];
      default: tx_byte = FILL_BYTE;
    endcase
  end

  tpmx_byte_shifter #(
    .SCK_HALF (SCK_HALF)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (kick),
    .tx_i   (tx_byte),
    .miso_i (spi_miso_i),
    .sclk_o (spi_sclk_o),
    .mosi_o (spi_mosi_o),
    .done_o (byte_done),
    .rx_o   (rx_byte)
  );

  assign store_en = byte_done && (phase == PH_DATA) && rd_i;

  tpmx_rx_store #(
    .MAX_BYTES (MAX_BYTES)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (store_en),
    .idx_i  (idx),
    .byte_i (rx_byte),
    .data_o (rdata_o)
  );

  assign busy_o = (phase != PH_IDLE);
  assign err_o  = err;
endmodule

// File: rtl/tpm_spi_xact_chk.sv
module tpm_spi_xact_chk #(
  parameter int unsigned MAX_BYTES = 64,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       err_o,
  input logic             spi_cs_n_o,
  input logic             spi_sclk_o,
  input logic             spi_mosi_o
);
  AST_SCLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sclk_o); // R9

  AST_MOSI_HELD_WHILE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk_o |-> $stable(spi_mosi_o)); // R9

  AST_DESELECTED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> spi_cs_n_o); // R10

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o); // R10

  AST_BAD_LEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && ((len_i == '0) || (len_i > LEN_W'(MAX_BYTES))))
      |=> (done_o && (err_o == 2'b01) && spi_cs_n_o)); // R3
endmodule

bind tpm_spi_xact tpm_spi_xact_chk #(
  .MAX_BYTES (MAX_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .len_i      (len_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .spi_cs_n_o (spi_cs_n_o),
  .spi_sclk_o (spi_sclk_o),
  .spi_mosi_o (spi_mosi_o)
);

// File: tb/tpm_spi_xact_bench.sv
module tpm_spi_xact_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 64;
  localparam int DW         = MAXB * 8;
  localparam int WAIT_LIM   = 12000;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          rd_i;
  logic [15:0]   addr_i;
  logic [6:0]    len_i;
  logic [15:0]   poll_lim_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          busy_o;
  logic          done_o;
  logic [1:0]    err_o;
  logic          cs_n;
  logic          sclk;
  logic          mosi;
  logic          miso;

  int n_chk;
  int n_bad;
  int cyc;

  tpm_spi_xact u_tpm_spi_xact (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .len_i      (len_i),
    .poll_lim_i (poll_lim_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .spi_cs_n_o (cs_n),
    .spi_sclk_o (sclk),
    .spi_mosi_o (mosi),
    .spi_miso_i (miso)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- target model ----------------
  int         nb;
  int         bc;
  int         cs_lows;
  int         stall_n;
  logic [7:0] sh;
  logic [7:0] mlog [0:127];
  logic [7:0] rresp [0:63];

  initial begin
    nb = 0; bc = 0; cs_lows = 0; stall_n = 0; sh = '0;
  end

  always @(posedge sclk or negedge cs_n) begin
    if (!sclk) begin
      nb = 0;
      bc = 0;
      cs_lows = cs_lows + 1;
    end else begin
      sh = {sh[6:0], mosi};
      bc = bc + 1;
      if (bc == 8) begin
        if (nb < 128) mlog[nb] = sh;
        nb = nb + 1;
        bc = 0;
      end
    end
  end

  function automatic logic [7:0] resp_at(input int n);
    if (n < 4) return 8'hFF;                    // ready bit set in header: must be ignored
    if (n < 4 + stall_n) return 8'hFE;          // not ready
    if (n == 4 + stall_n) return 8'h81;         // ready
    if (n - 5 - stall_n < 64) return rresp[n - 5 - stall_n];
    return 8'h00;
  endfunction

  logic [7:0] cur_resp;
  always_comb begin
    cur_resp = resp_at(nb);
    miso     = cur_resp[3'(7 - bc)];
  end

  // ---------------- watchdog ----------------
  initial cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < WAIT_LIM; i++) begin
      @(negedge clk);
      if (done_o) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  // Full transaction with expected values computed from the requirements.
  task automatic run_xact(input bit rd, input logic [15:0] addr, input int len,
                          input int stall, input int lim, input logic [DW-1:0] wd);
    bit         seen;
    int         lim_eff;
    bit         ok_path;
    int         exp_nb;
    int         lows0;
    logic [7:0] b0;
    lim_eff = (lim == 0) ? 1 : lim;
    ok_path = (stall < lim_eff);
    exp_nb  = ok_path ? (5 + stall + len) : (4 + lim_eff);
    stall_n = stall;
    for (int k = 0; k < 64; k++) rresp[k] = 8'($urandom);
    @(negedge clk);
    rd_i = rd; addr_i = addr; len_i = 7'(len); poll_lim_i = 16'(lim); wdata_i = wd;
    start_i = 1'b1;
    lows0 = cs_lows;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(seen);
    chk(seen, "R10 done seen", 64'(seen), 64'd1);
    chk(cs_n == 1'b1 && busy_o == 1'b0, "R10 cs released and idle at done", {62'd0, cs_n, busy_o}, 64'h2);
    chk(cs_lows - lows0 == 1, "R10 single cs low period", 64'(cs_lows - lows0), 64'd1);
    b0 = {rd, 1'b0, 6'(len - 1)};
    chk(mlog[0] == b0, "R1 header byte0", 64'(mlog[0]), 64'(b0));
    chk(mlog[1] == 8'hD4 && mlog[2] == addr[15:8] && mlog[3] == addr[7:0], "R2 header bytes",
        {40'd0, mlog[1], mlog[2], mlog[3]}, {40'd0, 8'hD4, addr});
    if (ok_path) begin
      chk(nb == exp_nb, "R4 R5 total bytes with stall", 64'(nb), 64'(exp_nb));
      chk(err_o == 2'b00, "R8 no error", 64'(err_o), 64'd0);
    end else begin
      chk(nb == exp_nb, "R6 bytes before timeout", 64'(nb), 64'(exp_nb));
      chk(err_o == 2'b10, "R6 timeout code", 64'(err_o), 64'd2);
    end
    for (int n = 4; n < 5 + stall && n < nb; n++)
      chk(mlog[n] == 8'h00, "R4 poll filler", 64'(mlog[n]), 64'd0);
    if (ok_path) begin
      for (int k = 0; k < len; k++) begin
        if (rd) begin
          chk(mlog[5 + stall + k] == 8'h00, "R8 read filler", 64'(mlog[5 + stall + k]), 64'd0);
          chk(rdata_o[k*8 +: 8] == rresp[k], "R8 read byte", 64'(rdata_o[k*8 +: 8]), 64'(rresp[k]));
        end else begin
          chk(mlog[5 + stall + k] == wd[k*8 +: 8], "R7 write byte",
              64'(mlog[5 + stall + k]), 64'(wd[k*8 +: 8]));
        end
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done one cycle", 64'(done_o), 64'd0);
  endtask

  task automatic run_bad_len(input int len);
    int lows0;
    lows0 = cs_lows;
    @(negedge clk);
    rd_i = 1'b1; len_i = 7'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1 && err_o == 2'b01, "R3 length refused", {62'd0, err_o}, 64'd1);
    repeat (3) @(negedge clk);
    chk(cs_lows == lows0 && cs_n == 1'b1 && busy_o == 1'b0, "R3 no bus activity",
        64'(cs_lows - lows0), 64'd0);
  endtask

  logic [DW-1:0] wrand;

  initial begin
    n_chk = 0; n_bad = 0;
    start_i = 0; rd_i = 0; addr_i = '0; len_i = 7'd1; poll_lim_i = 16'd6; wdata_i = '0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0 && busy_o == 1'b0 && done_o == 1'b0,
        "R11 reset state", {59'd0, cs_n, sclk, mosi, busy_o, done_o}, 64'h10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed: 32-bit write, LSB first on the wire (R7)
    run_xact(1'b0, 16'h0F90, 4, 0, 6, {{(DW-32){1'b0}}, 32'h1122_3344});
    // Directed: 32-bit read into rdata low bits (R8)
    run_xact(1'b1, 16'h0018, 4, 2, 6, '0);
    chk(rdata_o[31:0] == {rresp[3], rresp[2], rresp[1], rresp[0]}, "R8 32-bit value lsb first",
        64'(rdata_o[31:0]), 64'({rresp[3], rresp[2], rresp[1], rresp[0]}));
    // Length bounds
    run_xact(1'b1, 16'hABCD, 1, 0, 6, '0);
    for (int k = 0; k < MAXB; k++) wrand[k*8 +: 8] = 8'($urandom);
    run_xact(1'b0, 16'h1234, 64, 1, 6, wrand);
    run_xact(1'b1, 16'h4321, 64, 0, 6, '0);
    run_bad_len(0);   // R3
    run_bad_len(65);  // R3
    // Timeout boundary (R6): stall just under limit succeeds, at limit fails
    run_xact(1'b1, 16'h0024, 8, 5, 6, '0);
    run_xact(1'b1, 16'h0024, 8, 6, 6, '0);
    run_xact(1'b0, 16'h0024, 8, 200, 3, '0);
    run_xact(1'b1, 16'h0030, 2, 0, 0, '0);   // R6 limit 0 acts as 1, ready immediately
    run_xact(1'b1, 16'h0030, 2, 1, 0, '0);   // R6 limit 0 acts as 1, times out
    // Constrained random mix
    for (int t = 0; t < 30; t++) begin
      int len_r;
      int st_r;
      len_r = 1 + int'($urandom % 64);
      st_r  = int'($urandom % 6);
      for (int k = 0; k < MAXB; k++) wrand[k*8 +: 8] = 8'($urandom);
      run_xact(1'($urandom), 16'($urandom), len_r, st_r, 5, wrand);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule